// File: doc/BRIEF.md
# Dual-Address DMA Transfer Channel

This block is one DMA channel that copies data between two addresses, one unit per request. Software loads the two start addresses, a transfer count, the unit size (byte or word), a stepping mode for each pointer, an enable and an interrupt enable, all in one load strobe. Each accepted request becomes a read bus cycle at the source pointer and then a write bus cycle at the destination pointer. The data read is held in an internal buffer between the two cycles. After the write, both pointers step and the count drops by one.

When the count reaches zero, the channel clears its own enable and ignores further requests. If interrupt enable was set, it raises an interrupt that stays high until software clears it. Every bus cycle lasts one clock, and read data is taken combinationally in the read cycle.

A request that arrives while a transfer is in flight is held as one pending request and served next. The live pointers, the count and the enable can be read on output ports.

Top module: `dma_xfer_chan`

## Requirements
- R1: One cycle after `cfg_load`, `cur_src`, `cur_dst` and `cur_cnt` equal the loaded values, `en` equals `cfg_en`, `irq` is low, and the channel is idle.
- R2: An accepted request produces, in the next cycle, exactly one cycle with `bus_rd` high and `bus_addr` equal to the source pointer. The cycle after that has exactly one cycle with `bus_wr` high, `bus_addr` equal to the destination pointer, and `bus_wdata` equal to the data returned on `bus_rdata` during the read.
- R3: After each transfer the source pointer steps by its mode code `cfg_src_mode`: 2'b01 adds the step, 2'b10 subtracts it, 2'b00 and 2'b11 keep it. The step is 1 when `cfg_word` is 0 and 2 when it is 1. Arithmetic wraps modulo 2^ADDR_W.
- R4: The destination pointer follows the same rules under its own code `cfg_dst_mode`, independently of the source mode.
- R5: `cur_cnt` decreases by exactly one for each completed transfer.
- R6: When the decrement brings `cur_cnt` to zero, `en` falls in the same update. Requests after that start no bus cycle and leave the pointers and the count unchanged.
- R7: When the final transfer completes, `irq` goes high if and only if `cfg_ie` was loaded as 1. It then stays high until `irq_clr` or a new `cfg_load`.
- R8: A loaded count of zero runs 2^CNT_W transfers. The first transfer leaves `cur_cnt` at all ones and `en` high.
- R9: A request that arrives while a transfer is busy is held pending. It starts the next transfer right after the current one, with no new request needed.
- R10: While `en` is low, requests start no bus cycle and are not remembered for later.
- R11: `bus_word` reflects the loaded size during both bus cycles of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for all configuration fields |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_cnt | input | CNT_W | Transfer count (0 means 2^CNT_W) |
| cfg_word | input | 1 | Unit size: 0 byte, 1 word |
| cfg_src_mode | input | 2 | Source step mode: 01 up, 10 down, 00/11 fixed |
| cfg_dst_mode | input | 2 | Destination step mode, same coding |
| cfg_en | input | 1 | Enable value loaded with the strobe |
| cfg_ie | input | 1 | Interrupt enable loaded with the strobe |
| irq_clr | input | 1 | Clears the interrupt |
| req | input | 1 | Transfer request |
| bus_rdata | input | DATA_W | Read data, valid in the read cycle |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data (buffered read data) |
| bus_word | output | 1 | Current unit size |
| busy | output | 1 | A transfer is in flight |
| en | output | 1 | Channel enable |
| irq | output | 1 | Completion interrupt |
| cur_src | output | ADDR_W | Live source pointer |
| cur_dst | output | ADDR_W | Live destination pointer |
| cur_cnt | output | CNT_W | Live remaining count |

## Verification
The bench builds the channel with ADDR_W=8, CNT_W=4 and DATA_W=16. With an 8-bit address, starting pointers placed near both ends of the space make up, down, wraparound and fixed stepping all visible within a few transfers. With a 4-bit count, a loaded zero becomes a full 16-transfer run, so the maximum-length case is swept completely. This allows every pairing of the four source codes, four destination codes and both sizes to be run with several counts. Every bus cycle is compared against addresses and data computed arithmetically.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_UP    = 2'b01,
    AM_DOWN  = 2'b10,
    AM_KEEP  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_WRITE = 2'b10
  } xfer_state_e;
endpackage

// File: rtl/dma_ptr_step.sv
module dma_ptr_step #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  input  logic              word,
  output logic [ADDR_W-1:0] nxt
);
  import dma_chan_pkg::*;

  logic [ADDR_W-1:0] step;

  always_comb begin
    step = word ? ADDR_W'(2) : ADDR_W'(1);
    case (addr_mode_e'(mode))
      AM_UP:   nxt = cur + step;
      AM_DOWN: nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      abort,
  input  logic                      en,
  input  logic                      req,
  output dma_chan_pkg::xfer_state_e state
);
  import dma_chan_pkg::*;

  xfer_state_e st_q, st_d;
  logic        pend_q, pend_d;
  logic        launch;

  assign launch = en && (req || pend_q);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    if (abort) begin
      st_d   = ST_IDLE;
      pend_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE:  if (launch) st_d = ST_READ;
        ST_READ:  st_d = ST_WRITE;
        default:  st_d = ST_IDLE;
      endcase
      if (!en || st_q == ST_IDLE) pend_d = 1'b0;
      else if (req)               pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              cfg_word,
  input  logic [1:0]        cfg_src_mode,
  input  logic [1:0]        cfg_dst_mode,
  input  logic              cfg_en,
  input  logic              cfg_ie,
  input  logic              irq_clr,
  input  logic              req,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_word,
  output logic              busy,
  output logic              en,
  output logic              irq,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt
);
  import dma_chan_pkg::*;

  localparam int NPTR = 2;

  xfer_state_e       st;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [1:0]        smode_q, smode_d, dmode_q, dmode_d;
  logic              word_q, word_d, en_q, en_d, ie_q, ie_d, irq_q, irq_d;
  logic [ADDR_W-1:0] ptr_cur [NPTR];
  logic [ADDR_W-1:0] ptr_nxt [NPTR];
  logic [1:0]        ptr_mode [NPTR];

  dma_xfer_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (cfg_load),
    .en    (en_q),
    .req   (req),
    .state (st)
  );

  assign ptr_cur[0]  = src_q;
  assign ptr_cur[1]  = dst_q;
  assign ptr_mode[0] = smode_q;
  assign ptr_mode[1] = dmode_q;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    dma_ptr_step #(.ADDR_W(ADDR_W)) u_step (
      .cur  (ptr_cur[i]),
      .mode (ptr_mode[i]),
      .word (word_q),
      .nxt  (ptr_nxt[i])
    );
  end

  always_comb begin
    src_d = src_q;  dst_d = dst_q;  cnt_d = cnt_q;  buf_d = buf_q;
    smode_d = smode_q;  dmode_d = dmode_q;  word_d = word_q;
    en_d = en_q;  ie_d = ie_q;  irq_d = irq_q;
    if (cfg_load) begin
      src_d = cfg_src;  dst_d = cfg_dst;  cnt_d = cfg_cnt;
      smode_d = cfg_src_mode;  dmode_d = cfg_dst_mode;  word_d = cfg_word;
      en_d = cfg_en;  ie_d = cfg_ie;  irq_d = 1'b0;
    end else begin
      if (irq_clr) irq_d = 1'b0;
      if (st == ST_READ) buf_d = bus_rdata;
      if (st == ST_WRITE) begin
        src_d = ptr_nxt[0];
        dst_d = ptr_nxt[1];
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_d == '0) begin
          en_d = 1'b0;
          if (ie_q) irq_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;  dst_q <= '0;  cnt_q <= '0;  buf_q <= '0;
      smode_q <= '0;  dmode_q <= '0;  word_q <= 1'b0;
      en_q <= 1'b0;  ie_q <= 1'b0;  irq_q <= 1'b0;
    end else begin
      src_q <= src_d;  dst_q <= dst_d;  cnt_q <= cnt_d;  buf_q <= buf_d;
      smode_q <= smode_d;  dmode_q <= dmode_d;  word_q <= word_d;
      en_q <= en_d;  ie_q <= ie_d;  irq_q <= irq_d;
    end
  end

  assign bus_rd    = (st == ST_READ);
  assign bus_wr    = (st == ST_WRITE);
  assign bus_addr  = (st == ST_WRITE) ? dst_q : src_q;
  assign bus_wdata = buf_q;
  assign bus_word  = word_q;
  assign busy      = (st != ST_IDLE);
  assign en        = en_q;
  assign irq       = irq_q;
  assign cur_src   = src_q;
  assign cur_dst   = dst_q;
  assign cur_cnt   = cnt_q;
endmodule

// File: rtl/dma_xfer_chan_chk.sv
module dma_xfer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             busy,
  input logic             en,
  input logic             irq,
  input logic [CNT_W-1:0] cur_cnt
);
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !cfg_load |=> bus_wr);

  assert_wr_after_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd));

  assert_cnt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !cfg_load |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

  assert_en_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) && !$past(cfg_load) |-> cur_cnt == '0);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(en));

  assert_no_rd_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> en && busy);
endmodule

bind dma_xfer_chan dma_xfer_chan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_xfer_chan_bench.sv
module dma_xfer_chan_bench;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int DW = 16;

  logic          clk, rst_n, cfg_load, cfg_word, cfg_en, cfg_ie, irq_clr, req;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [CW-1:0] cfg_cnt;
  logic [1:0]    cfg_src_mode, cfg_dst_mode;
  logic [DW-1:0] bus_rdata, bus_wdata;
  logic          bus_rd, bus_wr, bus_word, busy, en, irq;
  logic [AW-1:0] bus_addr, cur_src, cur_dst;
  logic [CW-1:0] cur_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int cyc = 0;

  dma_xfer_chan #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u_dma_xfer_chan (.*);

  function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  function automatic logic [AW-1:0] stp(input logic [AW-1:0] a, input int m, input bit w);
    logic [AW-1:0] s;
    s = w ? 8'd2 : 8'd1;
    if (m == 1) return a + s;
    if (m == 2) return a - s;
    return a;
  endfunction

  assign bus_rdata = mem_of(bus_addr);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] c,
                      input int sm, input int dm, input bit w, input bit e, input bit ie);
    @(negedge clk);
    cfg_src = s;  cfg_dst = d;  cfg_cnt = c;
    cfg_src_mode = 2'(sm);  cfg_dst_mode = 2'(dm);  cfg_word = w;
    cfg_en = e;  cfg_ie = ie;  cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(cur_src == s && cur_dst == d, "R1 pointers", {cur_src, cur_dst}, {s, d});
    chk(cur_cnt == c && en == e && !irq && !busy, "R1 count/en/irq",
        {cur_cnt, en, irq, busy}, {c, e, 1'b0, 1'b0});
  endtask

  task automatic xfer(input logic [AW-1:0] s, input logic [AW-1:0] d, input bit w);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(bus_rd && !bus_wr && bus_addr == s, "R2 read cycle", {bus_rd, bus_addr}, {1'b1, s});
    chk(bus_word == w, "R11 size on read", bus_word, w);
    @(negedge clk);
    chk(bus_wr && !bus_rd && bus_addr == d, "R2 write cycle", {bus_wr, bus_addr}, {1'b1, d});
    chk(bus_wdata == mem_of(s), "R2 write data", bus_wdata, mem_of(s));
    chk(bus_word == w, "R11 size on write", bus_word, w);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;  cfg_load = 1'b0;  req = 1'b0;  irq_clr = 1'b0;
    cfg_src = '0;  cfg_dst = '0;  cfg_cnt = '0;  cfg_word = 1'b0;
    cfg_src_mode = '0;  cfg_dst_mode = '0;  cfg_en = 1'b0;  cfg_ie = 1'b0;
    repeat (3) @(negedge clk);
    chk(!en && !irq && !busy && !bus_rd && !bus_wr, "R1 reset state",
        {en, irq, busy, bus_rd, bus_wr}, 0);
    rst_n = 1'b1;

    begin : sweep
      int cset [4] = '{1, 3, 5, 0};
      int k = 0;
      for (int sm = 0; sm < 4; sm++)
        for (int dm = 0; dm < 4; dm++)
          for (int w = 0; w < 2; w++) begin
            logic [AW-1:0] s, d;
            logic [CW-1:0] c;
            int n;
            bit ie;
            int rd0;
            c  = CW'(cset[k % 4]);
            n  = (c == 0) ? (1 << CW) : int'(c);
            ie = k[0];
            s  = 8'hFD;
            d  = 8'h02;
            load(s, d, c, sm, dm, w[0], 1'b1, ie);
            for (int t = 0; t < n; t++) begin
              xfer(s, d, w[0]);
              s = stp(s, sm, w[0]);
              d = stp(d, dm, w[0]);
              chk(cur_src == s, "R3 source step", cur_src, s);
              chk(cur_dst == d, "R4 destination step", cur_dst, d);
              chk(cur_cnt == CW'(c - CW'(t + 1)), "R5 count", cur_cnt, CW'(c - CW'(t + 1)));
              if (c == 0 && t == 0)
                chk(cur_cnt == {CW{1'b1}} && en, "R8 zero count wraps", {cur_cnt, en}, {{CW{1'b1}}, 1'b1});
              if (t < n - 1) chk(en && !irq, "R6 still enabled", {en, irq}, 2'b10);
            end
            chk(!en, "R6 enable cleared", en, 0);
            chk(irq == ie, "R7 irq follows ie", irq, ie);
            rd0 = rd_cnt;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            repeat (3) @(negedge clk);
            chk(rd_cnt == rd0 && cur_cnt == 0 && cur_src == s, "R6 request ignored after end",
                {rd_cnt[7:0], cur_cnt, cur_src}, {rd0[7:0], 4'h0, s});
            chk(irq == ie, "R7 irq held", irq, ie);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk(!irq, "R7 irq cleared", irq, 0);
            k++;
          end
    end

    begin : pend_test
      int rd0;
      load(8'h10, 8'h80, 4'd3, 1, 1, 1'b0, 1'b1, 1'b0);
      rd0 = rd_cnt;
      req = 1'b1;
      @(negedge clk);
      chk(bus_rd, "R9 first read", bus_rd, 1);
      @(negedge clk);
      req = 1'b0;
      repeat (5) @(negedge clk);
      chk(rd_cnt == rd0 + 2, "R9 pending served", rd_cnt, rd0 + 2);
      chk(cur_cnt == 4'd1 && cur_src == 8'h12 && cur_dst == 8'h82, "R9 two transfers",
          {cur_cnt, cur_src, cur_dst}, {4'd1, 8'h12, 8'h82});
    end

    begin : disabled_test
      int rd0;
      load(8'h40, 8'h50, 4'd2, 1, 1, 1'b1, 1'b0, 1'b1);
      rd0 = rd_cnt;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (3) @(negedge clk);
      chk(rd_cnt == rd0 && cur_cnt == 4'd2 && cur_src == 8'h40, "R10 disabled ignores",
          {rd_cnt[7:0], cur_cnt, cur_src}, {rd0[7:0], 4'd2, 8'h40});
      load(8'h40, 8'h50, 4'd2, 1, 1, 1'b1, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      chk(rd_cnt == rd0 && !busy, "R10 nothing remembered", rd_cnt, rd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule